// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a general-purpose I/O port of `W` bits (eight by default). Three views per bit sit on a small synchronous register bus. The first is a direction register. The second is an output register that also serves as the pull-up request when a bit is an input. The third is a pin view that returns the synchronized pad level. For every bit the block drives three pad-side signals: an output enable, a drive value and a pull-up enable. A single chip-level input switches every pull-up off at once.

Pad levels pass through a latch that is open while the clock is low, then through a flop on the rising edge, before they can be read. A write of ones to the pin-view address inverts the matching output-register bits, so one bus write flips one or more bits without a read-modify-write. Reads are combinational on the address. Writes land on the next rising clock edge.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output registers both read 0x00, every pad output enable is 0 and every pull-up enable is 0.
- R2: A bit whose direction is 1 has its output enable at 1, its drive value equal to its output-register bit, and its pull-up off.
- R3: A bit whose direction is 0 and whose output-register bit is 0 has output enable 0, drive value 0 and pull-up 0.
- R4: A bit whose direction is 0 and whose output-register bit is 1 has its pull-up on while the global pull-up disable is 0.
- R5: While the global pull-up disable is 1, every pull-up enable is 0, whatever the direction and output registers hold.
- R6: A write to address 2 (pin view) inverts each output-register bit whose write-data bit is 1 and leaves the bits with 0 unchanged. This holds for input and output bits alike, and the direction register is not touched.
- R7: A read of address 2 returns the pad level after the latch-plus-flop synchronizer, for input and output bits alike. A pad change made while the clock is high is not visible before the next rising edge and is visible after the rising edge that follows the next low phase.
- R8: Reads of address 0 return the direction register and reads of address 1 return the output register, not the pad level.
- R9: A write takes effect on the next rising clock edge and not before. A write to address 3 changes nothing, and reads of address 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 direction, 1 output, 2 pin view, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for the selected address |
| pu_disable | input | 1 | Global pull-up disable |
| pad_in | input | W | Raw pad levels |
| pad_oe | output | W | Per-bit output enable |
| pad_out | output | W | Per-bit drive value |
| pad_pu | output | W | Per-bit pull-up enable |

## Verification
The bench uses the default width of eight. With the direction set to 0xF0, one write pattern exercises driven-high, driven-low, pulled-up and floating bits together. A single toggle write then reaches both input and output halves. The pad pattern is changed while the clock is high, so the bench can check the synchronizer in the cycle before the change appears and again in the cycle it does. It then reads the same pad pattern with every bit set as an input.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_PIN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level_o
);
    logic [W-1:0] lat_q;
    logic [W-1:0] sync_d, sync_q;

    // first stage: open while the clock is low
    always_latch begin
        if (!clk) lat_q <= pad_in;
    end

    always_comb begin
        sync_d = lat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      out_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] out;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                SEL_DIR: st_d.dir = wr_data;
                SEL_OUT: st_d.out = wr_data;
                SEL_PIN: st_d.out = st_q.out ^ wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o = st_q.dir;
    assign out_o = st_q.out;

    a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_PIN) |=>
            (out_o == ($past(out_o) ^ $past(wr_data))) && $stable(dir_o));

    a_r8_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SEL_DIR) |=> (dir_o == $past(wr_data)) && $stable(out_o));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || addr == SEL_NONE) |=> $stable(dir_o) && $stable(out_o));

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] out_i,
    input  logic         pu_disable,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            pad_oe[i]  = dir_i[i];
            pad_out[i] = dir_i[i] & out_i[i];
            pad_pu[i]  = ~dir_i[i] & out_i[i] & ~pu_disable;
        end
    end

    a_r5_global_pu_off: assert property (@(posedge clk) disable iff (!rst_n)
        pu_disable |-> (pad_pu == '0));

    a_r2_no_pu_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe != '0) |-> ((pad_pu & pad_oe) == '0));

    a_r3_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe != {W{1'b1}}) |-> ((pad_out & ~pad_oe) == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              pu_disable,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu
);
    logic [W-1:0] dir_q, out_q, level_q;

    gpio_port_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wr_data (bus_wdata),
        .dir_o   (dir_q),
        .out_o   (out_q)
    );

    gpio_pad_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .level_o (level_q)
    );

    gpio_pad_drive #(.W(W)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_i      (dir_q),
        .out_i      (out_q),
        .pu_disable (pu_disable),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_DIR: bus_rdata = dir_q;
            SEL_OUT: bus_rdata = out_q;
            SEL_PIN: bus_rdata = level_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
    localparam int W = 8;

    typedef enum int {K_RD, K_OE, K_OUT, K_PU} kind_e;
    typedef struct {
        string      req;
        kind_e      kind;
        logic [7:0] mask;
        logic [7:0] exp;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         pu_disable = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe, pad_out, pad_pu;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;

    always #2 clk = ~clk;

    gpio_port #(.W(W)) u_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pu_disable(pu_disable),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // monitor: compare pending items in the low phase
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    got = bus_rdata;
                    K_OE:    got = pad_oe;
                    K_OUT:   got = pad_out;
                    default: got = pad_pu;
                endcase
                n_chk++;
                if ((got & it.mask) !== (it.exp & it.mask)) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h mask=%h",
                             it.req, it.kind, got & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    task automatic push(string req, kind_e k, logic [7:0] mask, logic [7:0] exp);
        item_t it;
        it.req = req; it.kind = k; it.mask = mask; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
        bus_addr = a;
        push(req, K_RD, 8'hFF, exp);
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        step();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd("R1", 2'd0, 8'h00); settle();
        rd("R1", 2'd1, 8'h00);
        push("R1", K_OE, 8'hFF, 8'h00);
        push("R1", K_PU, 8'hFF, 8'h00);
        settle();

        // R9 write not visible before the edge
        step();
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hF0;
        push("R9", K_RD, 8'hFF, 8'h00);
        settle();
        step();
        bus_wr = 1'b0;
        rd("R8", 2'd0, 8'hF0);
        push("R2", K_OE, 8'hFF, 8'hF0);
        settle();

        // mixed pattern: R2 R3 R4
        wr(2'd1, 8'hA5);
        rd("R8", 2'd1, 8'hA5);
        push("R2", K_OUT, 8'hFF, 8'hA0);
        push("R4", K_PU, 8'hFF, 8'h05);
        push("R3", K_PU, 8'h0A, 8'h00);
        push("R3", K_OUT, 8'h0F, 8'h00);
        settle();

        // R5 global disable
        step(); pu_disable = 1'b1;
        push("R5", K_PU, 8'hFF, 8'h00);
        push("R2", K_OUT, 8'hFF, 8'hA0);
        settle();
        step(); pu_disable = 1'b0;
        push("R4", K_PU, 8'hFF, 8'h05);
        settle();

        // R9 unused address
        wr(2'd3, 8'hFF);
        rd("R9", 2'd0, 8'hF0); settle();
        rd("R9", 2'd1, 8'hA5); settle();
        rd("R9", 2'd3, 8'h00); settle();

        // R6 toggle through pin address
        wr(2'd2, 8'h3C);
        rd("R6", 2'd1, 8'h99);
        push("R6", K_OUT, 8'hFF, 8'h90);
        push("R6", K_PU, 8'hFF, 8'h09);
        settle();
        rd("R6", 2'd0, 8'hF0); settle();
        wr(2'd2, 8'h00);
        rd("R6", 2'd1, 8'h99); settle();

        // R7 synchronized pin read
        step(); pad_in = 8'h5A;
        rd("R7", 2'd2, 8'h00); settle();
        step();
        rd("R7", 2'd2, 8'h5A); settle();
        step(); pad_in = 8'hC3;
        rd("R7", 2'd2, 8'h5A); settle();
        step();
        rd("R7", 2'd2, 8'hC3); settle();

        // all inputs: R7 and R4/R3
        wr(2'd0, 8'h00);
        rd("R7", 2'd2, 8'hC3);
        push("R3", K_OE, 8'hFF, 8'h00);
        push("R3", K_OUT, 8'hFF, 8'h00);
        push("R4", K_PU, 8'hFF, 8'h99);
        settle();

        repeat (2) step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule